// File: doc/BRIEF.md
# Single-Clock FIFO with Mark/Retransmit and Fall-Through Output

The block stores words in a parameterised power-of-two deep buffer and delivers them in arrival order. Its output timing is picked when the master reset is taken. In standard timing, a word is shown only after a read is requested. In fall-through timing, the oldest word is loaded into the output register on its own, and a ready flag marks it as valid. The two shared flag pins change meaning with the timing mode: empty/full in standard timing, output-ready/input-ready in fall-through timing. Three level flags also come from the stored word count: half-full, almost-empty and almost-full. The almost-empty and almost-full thresholds are loaded at master reset.

A read position can be marked. A later retransmit request moves the read pointer back to that position, or to location zero if nothing is marked, and leaves the write side alone. This lets a consumer replay a frame. A partial reset empties the buffer and forgets the mark, but keeps the timing mode and both thresholds. The master reset (`mrst_i`, synchronous) reloads them from the configuration inputs. `rst_ni` is the asynchronous power-on reset: it selects standard timing and the default thresholds.

Top module: `rt_fifo`

## Requirements
- R1: While `mrst_i` is high at a clock edge, both pointers and `rdata_o` go to zero, the mark is forgotten, and the timing mode (`fwft_sel_i`: 0 = standard, 1 = fall-through) and both thresholds are loaded. After `rst_ni` the block is in standard timing, empty, with `rdata_o` = 0.
- R2: In standard timing, `rdata_o` changes only on an accepted read (`rd_en_i` with at least one stored word). Words come out in write order. `flag_e_o` is 1 exactly when no word is stored, and a read of an empty buffer leaves `rdata_o` unchanged.
- R3: A write while DEPTH words are stored is dropped. `flag_f_o` is 1 when full in standard timing. In fall-through timing it is 1 when not full (input ready).
- R4: In fall-through timing, a word written into an empty buffer appears on `rdata_o` with `flag_e_o` = 1 (output ready) after the third clock edge that follows its write edge, with no read request.
- R5: In fall-through timing, every later word is loaded only on an edge where `rd_en_i` is high. A read with no word left drops `flag_e_o` to 0.
- R6: `almost_empty_o` is 1 when the stored count is below the empty threshold.
- R7: `almost_full_o` is 1 when the number of free locations is at or below the full threshold.
- R8: `half_full_o` is 1 when the stored count exceeds DEPTH/2.
- R9: `mark_i` at an edge records a location. In standard timing it records the location being read at that edge. In fall-through timing it records the word currently shown on `rdata_o`, provided output-ready is 1.
- R10: `rt_i` at an edge sets the read pointer to the mark, or to zero without a mark. It takes priority over a read and a mark in the same cycle and does not move the write pointer. The stored count in the buffer (the output register excluded) counts the word that is shown again.
- R11: After a retransmit edge, `flag_e_o` is forced to empty (standard timing) for one cycle, or to not ready (fall-through timing) until the marked word is reloaded two edges later.
- R12: `prst_i` zeroes both pointers, `rdata_o` and the mark. It keeps the timing mode and thresholds and ignores the configuration inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low power-on reset |
| mrst_i | input | 1 | Synchronous master reset, loads configuration |
| prst_i | input | 1 | Synchronous partial reset, keeps configuration |
| fwft_sel_i | input | 1 | Timing mode sampled at master reset (1 = fall-through) |
| ae_off_i | input | CW | Almost-empty threshold sampled at master reset |
| af_off_i | input | CW | Almost-full threshold sampled at master reset |
| wr_en_i | input | 1 | Write request |
| wdata_i | input | DW | Write data |
| rd_en_i | input | 1 | Read request |
| mark_i | input | 1 | Record current read location |
| rt_i | input | 1 | Retransmit from mark |
| rdata_o | output | DW | Output register |
| flag_e_o | output | 1 | Empty (standard) / output ready (fall-through) |
| flag_f_o | output | 1 | Full (standard) / input ready (fall-through) |
| half_full_o | output | 1 | Count above half depth |
| almost_empty_o | output | 1 | Count below empty threshold |
| almost_full_o | output | 1 | Free space at or below full threshold |

## Verification
A vector walk in standard timing fills the buffer past full and then drains it past empty, so that every level flag changes at its exact threshold count. The same walk shows that a write into a full buffer and a read from an empty one are both dropped. Fall-through runs measure the first-word latency edge by edge and separate automatic loading from loading on request. Marked and unmarked retransmits in both timing modes separate the jump to the mark from the jump to zero. Partial resets taken while the configuration inputs hold opposite values show that the mode and thresholds survive and that the mark does not.

// File: rtl/rt_fifo_pkg.sv
package rt_fifo_pkg;
  typedef enum logic {
    MODE_STD  = 1'b0,
    MODE_FWFT = 1'b1
  } rd_mode_e;
endpackage

// File: rtl/rt_fifo_cfg.sv
module rt_fifo_cfg
  import rt_fifo_pkg::*;
#(
  parameter int CW     = 5,
  parameter int AE_DEF = 2,
  parameter int AF_DEF = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          fwft_i,
  input  logic [CW-1:0] ae_off_i,
  input  logic [CW-1:0] af_off_i,
  output rd_mode_e      mode_o,
  output logic [CW-1:0] ae_off_o,
  output logic [CW-1:0] af_off_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_o   <= MODE_STD;
      ae_off_o <= CW'(AE_DEF);
      af_off_o <= CW'(AF_DEF);
    end else if (load_i) begin
      mode_o   <= fwft_i ? MODE_FWFT : MODE_STD;
      ae_off_o <= ae_off_i;
      af_off_o <= af_off_i;
    end
  end

  p_cfg_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(mode_o) && $stable(ae_off_o) && $stable(af_off_o));
endmodule

// File: rtl/rt_fifo_store.sv
module rt_fifo_store #(
  parameter int DW    = 8,
  parameter int DEPTH = 16,
  parameter int AW    = 4
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/rt_fifo_flags.sv
module rt_fifo_flags #(
  parameter int DEPTH = 16,
  parameter int CW    = 5
) (
  input  logic [CW-1:0] count_i,
  input  logic [CW-1:0] ae_off_i,
  input  logic [CW-1:0] af_off_i,
  output logic          empty_o,
  output logic          full_o,
  output logic          half_o,
  output logic          aempty_o,
  output logic          afull_o
);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [CW-1:0] HALF_CNT = CW'(DEPTH / 2);

  logic [CW-1:0] free_cnt;

  assign free_cnt = FULL_CNT - count_i;
  assign empty_o  = (count_i == '0);
  assign full_o   = (count_i == FULL_CNT);
  assign half_o   = (count_i > HALF_CNT);
  assign aempty_o = (count_i < ae_off_i);
  assign afull_o  = (free_cnt <= af_off_i);
endmodule

// File: rtl/rt_fifo.sv
module rt_fifo
  import rt_fifo_pkg::*;
#(
  parameter int DW     = 8,
  parameter int DEPTH  = 16,
  parameter int AE_DEF = 2,
  parameter int AF_DEF = 2,
  localparam int AW    = $clog2(DEPTH),
  localparam int CW    = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          mrst_i,
  input  logic          prst_i,
  input  logic          fwft_sel_i,
  input  logic [CW-1:0] ae_off_i,
  input  logic [CW-1:0] af_off_i,
  input  logic          wr_en_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          rd_en_i,
  input  logic          mark_i,
  input  logic          rt_i,
  output logic [DW-1:0] rdata_o,
  output logic          flag_e_o,
  output logic          flag_f_o,
  output logic          half_full_o,
  output logic          almost_empty_o,
  output logic          almost_full_o
);
  rd_mode_e      mode;
  logic [CW-1:0] ae_off, af_off;
  logic [CW-1:0] wptr, rptr, mark_ptr, wptr_d1, wptr_d2;
  logic [CW-1:0] count, rd_cnt;
  logic          mark_vld, or_q, rt_blk;
  logic [DW-1:0] rdata_q, mem_rd;
  logic          empty, full;
  logic          rst_any, fwft, wr_acc, rd_std, fetch, pop;

  rt_fifo_cfg #(.CW(CW), .AE_DEF(AE_DEF), .AF_DEF(AF_DEF)) u_cfg (
    .clk_i, .rst_ni, .load_i(mrst_i), .fwft_i(fwft_sel_i),
    .ae_off_i, .af_off_i,
    .mode_o(mode), .ae_off_o(ae_off), .af_off_o(af_off)
  );

  rt_fifo_store #(.DW(DW), .DEPTH(DEPTH), .AW(AW)) u_store (
    .clk_i, .we_i(wr_acc), .waddr_i(wptr[AW-1:0]), .wdata_i,
    .raddr_i(rptr[AW-1:0]), .rdata_o(mem_rd)
  );

  rt_fifo_flags #(.DEPTH(DEPTH), .CW(CW)) u_flags (
    .count_i(count), .ae_off_i(ae_off), .af_off_i(af_off),
    .empty_o(empty), .full_o(full), .half_o(half_full_o),
    .aempty_o(almost_empty_o), .afull_o(almost_full_o)
  );

  assign rst_any = mrst_i | prst_i;
  assign fwft    = (mode == MODE_FWFT);
  assign count   = wptr - rptr;
  // read side sees writes two cycles late in fall-through timing
  assign rd_cnt  = wptr_d2 - rptr;
  assign wr_acc  = wr_en_i && !full && !rst_any;
  assign rd_std  = !fwft && rd_en_i && !empty && !rt_blk && !rt_i;
  assign fetch   = fwft && !rt_blk && !rt_i && (rd_cnt != '0) && (!or_q || rd_en_i);
  assign pop     = rd_std || fetch;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr     <= '0;
      rptr     <= '0;
      wptr_d1  <= '0;
      wptr_d2  <= '0;
      mark_ptr <= '0;
      mark_vld <= 1'b0;
      or_q     <= 1'b0;
      rt_blk   <= 1'b0;
      rdata_q  <= '0;
    end else if (rst_any) begin
      wptr     <= '0;
      rptr     <= '0;
      wptr_d1  <= '0;
      wptr_d2  <= '0;
      mark_ptr <= '0;
      mark_vld <= 1'b0;
      or_q     <= 1'b0;
      rt_blk   <= 1'b0;
      rdata_q  <= '0;
    end else begin
      if (wr_acc) wptr <= wptr + 1'b1;
      wptr_d1 <= wptr;
      wptr_d2 <= wptr_d1;
      rt_blk  <= rt_i;
      if (rt_i) begin
        rptr <= mark_vld ? mark_ptr : '0;
        or_q <= 1'b0;
      end else begin
        if (pop) begin
          rptr    <= rptr + 1'b1;
          rdata_q <= mem_rd;
        end
        if (fetch)        or_q <= 1'b1;
        else if (rd_en_i) or_q <= 1'b0;
        if (mark_i && !fwft) begin
          mark_ptr <= rptr;
          mark_vld <= 1'b1;
        end else if (mark_i && or_q) begin
          mark_ptr <= rptr - 1'b1;  // word on the output
          mark_vld <= 1'b1;
        end
      end
    end
  end

  assign rdata_o  = rdata_q;
  assign flag_e_o = fwft ? or_q : (empty || rt_blk);
  assign flag_f_o = fwft ? !full : full;

  p_no_overflow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count <= CW'(DEPTH));
  p_full_drop_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full && wr_en_i && !rst_any |=> wptr == $past(wptr));
  p_rt_wptr_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rt_i && !wr_en_i && !rst_any |=> $stable(wptr));
  p_rt_flag_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rt_i && !rst_any |=> (fwft ? !flag_e_o : flag_e_o));
  p_prst_clear_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prst_i |=> rdata_o == '0 && wptr == '0 && rptr == '0);
  p_prst_keep_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prst_i && !mrst_i |=> mode == $past(mode));
endmodule

// File: tb/rt_fifo_tb_top.sv
`timescale 1ns/1ps
module rt_fifo_tb_top;
  localparam int DW = 8;
  localparam int DEPTH = 8;
  localparam int CW = 4;

  typedef struct packed {
    logic wr; logic [7:0] d; logic rd; logic [7:0] q;
    logic fe; logic ff; logic ae; logic af; logic hf;
  } vec_t;

  // standard timing, empty threshold 2, full threshold 2
  localparam vec_t VEC [21] = '{
    '{1'b1, 8'h11, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
    '{1'b1, 8'h22, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
    '{1'b0, 8'h00, 1'b1, 8'h11, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
    '{1'b1, 8'h33, 1'b1, 8'h22, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
    '{1'b1, 8'h44, 1'b0, 8'h22, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
    '{1'b1, 8'h55, 1'b0, 8'h22, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
    '{1'b1, 8'h66, 1'b0, 8'h22, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
    '{1'b1, 8'h77, 1'b0, 8'h22, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1},
    '{1'b1, 8'h88, 1'b0, 8'h22, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1},
    '{1'b1, 8'h99, 1'b0, 8'h22, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1},
    '{1'b1, 8'hAA, 1'b0, 8'h22, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1},
    '{1'b1, 8'hBB, 1'b0, 8'h22, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1},
    '{1'b0, 8'h00, 1'b1, 8'h33, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1},
    '{1'b0, 8'h00, 1'b1, 8'h44, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1},
    '{1'b0, 8'h00, 1'b1, 8'h55, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1},
    '{1'b0, 8'h00, 1'b1, 8'h66, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
    '{1'b0, 8'h00, 1'b1, 8'h77, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
    '{1'b0, 8'h00, 1'b1, 8'h88, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
    '{1'b0, 8'h00, 1'b1, 8'h99, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
    '{1'b0, 8'h00, 1'b1, 8'hAA, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0},
    '{1'b0, 8'h00, 1'b1, 8'hAA, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0}
  };

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic mrst_i = 1'b0, prst_i = 1'b0, fwft_sel_i = 1'b0;
  logic [CW-1:0] ae_off_i = '0, af_off_i = '0;
  logic wr_en_i = 1'b0, rd_en_i = 1'b0, mark_i = 1'b0, rt_i = 1'b0;
  logic [DW-1:0] wdata_i = '0;
  logic [DW-1:0] rdata_o;
  logic flag_e_o, flag_f_o, half_full_o, almost_empty_o, almost_full_o;
  int n_chk = 0, n_err = 0;

  always #4 clk_i = ~clk_i;

  rt_fifo #(.DW(DW), .DEPTH(DEPTH), .AE_DEF(2), .AF_DEF(2)) dut_i (
    .clk_i, .rst_ni, .mrst_i, .prst_i, .fwft_sel_i, .ae_off_i, .af_off_i,
    .wr_en_i, .wdata_i, .rd_en_i, .mark_i, .rt_i,
    .rdata_o, .flag_e_o, .flag_f_o, .half_full_o, .almost_empty_o, .almost_full_o
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic idle();
    wr_en_i = 0; rd_en_i = 0; mark_i = 0; rt_i = 0; mrst_i = 0; prst_i = 0;
  endtask

  task automatic master(input logic fw, input int ae, input int af);
    idle();
    mrst_i = 1; fwft_sel_i = fw; ae_off_i = CW'(ae); af_off_i = CW'(af);
    step();
    mrst_i = 0;
  endtask

  task automatic wr(input logic [7:0] d);
    idle(); wr_en_i = 1; wdata_i = d; step(); wr_en_i = 0;
  endtask

  task automatic rd();
    idle(); rd_en_i = 1; step(); rd_en_i = 0;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_err++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    // R1 power-on state
    chk("R1 rdata", rdata_o, 0);
    chk("R1 empty", flag_e_o, 1);
    chk("R1 full", flag_f_o, 0);
    chk("R1 ae", almost_empty_o, 1);
    chk("R1 af", almost_full_o, 0);
    chk("R1 hf", half_full_o, 0);

    master(1'b0, 2, 2);
    for (int i = 0; i < 21; i++) begin
      idle();
      wr_en_i = VEC[i].wr; wdata_i = VEC[i].d; rd_en_i = VEC[i].rd;
      step();
      chk($sformatf("R2 rdata v%0d", i), rdata_o, VEC[i].q);
      chk($sformatf("R2 empty v%0d", i), flag_e_o, VEC[i].fe);
      chk($sformatf("R3 full v%0d", i), flag_f_o, VEC[i].ff);
      chk($sformatf("R6 ae v%0d", i), almost_empty_o, VEC[i].ae);
      chk($sformatf("R7 af v%0d", i), almost_full_o, VEC[i].af);
      chk($sformatf("R8 hf v%0d", i), half_full_o, VEC[i].hf);
    end
    idle();

    // R1 master reset clears the output register
    master(1'b1, 1, 1);
    chk("R1 mrst rdata", rdata_o, 0);
    chk("R1 mrst not ready", flag_e_o, 0);

    // R4 first word latency
    wr(8'h5A);
    chk("R4 edge0", flag_e_o, 0);
    step(); chk("R4 edge1", flag_e_o, 0);
    step(); chk("R4 edge2", flag_e_o, 0);
    step(); chk("R4 edge3 ready", flag_e_o, 1);
    chk("R4 edge3 data", rdata_o, 8'h5A);

    // R5 later words need a read
    wr(8'h6B);
    repeat (4) step();
    chk("R5 held", rdata_o, 8'h5A);
    rd(); chk("R5 next data", rdata_o, 8'h6B);
    chk("R5 next ready", flag_e_o, 1);
    rd(); chk("R5 ready drop", flag_e_o, 0);
    chk("R3 input ready", flag_f_o, 1);
    for (int i = 0; i < 9; i++) wr(8'(i));
    chk("R3 input not ready", flag_f_o, 0);

    // R12 partial reset keeps fall-through timing
    idle(); prst_i = 1; fwft_sel_i = 0; step(); prst_i = 0;
    chk("R12 rdata", rdata_o, 0);
    chk("R12 not ready", flag_e_o, 0);
    wr(8'h7C);
    step(); step();
    chk("R12 mode kept before", flag_e_o, 0);
    step();
    chk("R12 mode kept ready", flag_e_o, 1);
    chk("R12 mode kept data", rdata_o, 8'h7C);

    // R9 R10 R11 fall-through retransmit
    wr(8'h8D); wr(8'h9E);
    repeat (3) step();
    idle(); mark_i = 1; step(); mark_i = 0;
    rd(); chk("R9 fw read1", rdata_o, 8'h8D);
    rd(); chk("R9 fw read2", rdata_o, 8'h9E);
    idle(); rt_i = 1; step(); rt_i = 0;
    chk("R11 fw not ready", flag_e_o, 0);
    step(); chk("R11 fw still not ready", flag_e_o, 0);
    step(); chk("R11 fw ready", flag_e_o, 1);
    chk("R10 fw replay", rdata_o, 8'h7C);
    rd(); chk("R10 fw replay next", rdata_o, 8'h8D);

    // R9 R10 R11 standard retransmit
    master(1'b0, 3, 1);
    wr(8'hB0); wr(8'hB1); wr(8'hB2); wr(8'hB3);
    rd(); chk("R2 std b0", rdata_o, 8'hB0);
    idle(); rd_en_i = 1; mark_i = 1; step(); idle();
    chk("R9 std marked read", rdata_o, 8'hB1);
    rd(); chk("R2 std b2", rdata_o, 8'hB2);
    idle(); rt_i = 1; rd_en_i = 1; step(); idle();
    chk("R10 rt beats read", rdata_o, 8'hB2);
    chk("R11 std empty", flag_e_o, 1);
    step(); chk("R11 std empty released", flag_e_o, 0);
    rd(); chk("R9 std replay", rdata_o, 8'hB1);
    rd(); chk("R10 std replay2", rdata_o, 8'hB2);
    rd(); chk("R10 std replay3", rdata_o, 8'hB3);
    chk("R10 wptr kept", flag_e_o, 1);

    // R12 partial reset keeps standard timing and thresholds, drops mark
    idle(); prst_i = 1; fwft_sel_i = 1; ae_off_i = 4'd1; step(); prst_i = 0;
    chk("R12 std rdata", rdata_o, 0);
    chk("R12 std empty", flag_e_o, 1);
    wr(8'hC0);
    chk("R12 std not empty", flag_e_o, 0);
    chk("R12 std no auto load", rdata_o, 0);
    wr(8'hC1);
    chk("R12 ae threshold kept", almost_empty_o, 1);
    wr(8'hC2);
    chk("R6 ae at threshold", almost_empty_o, 0);
    rd(); chk("R2 c0", rdata_o, 8'hC0);
    rd(); chk("R2 c1", rdata_o, 8'hC1);
    idle(); rt_i = 1; step(); rt_i = 0;
    step();
    rd(); chk("R10 no mark to zero", rdata_o, 8'hC0);

    finish_run();
  end
endmodule